// File: doc/BRIEF.md
# USB Supply Sequencing Controller

This block sequences the supply for a USB device interface. It takes a digital VBUS-valid level from a comparator outside the block, a device-enable level and a low-power-off flag. From these it drives a regulator-on control, times the regulator's worst-case settling period and then reports the supply as ready. A small 32-bit register port lets software read three sticky event flags and clear them. Software also sets interrupt enables, assigns each event a publish channel and reads a live status word.

Each event can drive a one-cycle publish strobe with its own channel index, which lets other hardware react without software. If VBUS becomes valid while the system is in its low-power-off state, the block raises a wake pulse and latches a VBUS reset-reason bit.

Top module: `usb_supply_seq`

## Requirements
- R1: `reg_on` is a register that is 1 exactly when, at the previous clock edge, `usb_en` was 1 and the synchronized VBUS level was 1. Losing either condition turns it off at the next edge.
- R2: After `reg_on` rises, `pwr_ready` rises exactly SETTLE_CYC clock edges later and raises the power-ready event. When the regulator turns off, `pwr_ready` drops in the same cycle as `reg_on`, and a later turn-on restarts the full settling period.
- R3: `vbus_async` passes through a two-flop synchronizer. A 0-to-1 change of the synchronized level raises the detected event, and a 1-to-0 change raises the removed event.
- R4: The event flags sit in bit 0 of offsets 0x100 (detected), 0x104 (removed) and 0x108 (power-ready), and reset to 0. Software writing 0 to a flag clears it. Writing 1 has no effect. A hardware set in the same cycle wins over a clear.
- R5: The interrupt-enable mask at 0x300 is loaded directly by a write. Bit 0 enables detected, bit 1 enables removed and bit 2 enables power-ready. The mask resets to 0.
- R6: Writing 1s to 0x304 sets those mask bits and writing 1s to 0x308 clears them. Zero bits have no effect. Offsets 0x300, 0x304 and 0x308 all read back the mask.
- R7: The status word at 0x400 is read-only. Bit 0 is the synchronized VBUS level and bit 1 equals `pwr_ready`.
- R8: The publish registers sit at 0x180, 0x184 and 0x188, one per event in that order. Each holds a channel in bits 7:0 and an enable in bit 31, and resets to 0. When an event fires with its enable set, `pub_stb[i]` pulses for one cycle with the channel on `pub_chan[8*i+7:8*i]`. With the enable clear, no pulse appears.
- R9: `irq` is a register equal to the OR over all events of (flag AND mask bit).
- R10: A synchronized VBUS rise while `sys_off` is 1 gives a one-cycle `wake_req` pulse and sets `rst_reason_vbus`. That bit stays set until reset. A rise with `sys_off` at 0 does neither.
- R11: A read returns data on `bus_rdata` one cycle after `bus_rd`. Unmapped offsets read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vbus_async | input | 1 | VBUS-valid level from the comparator, asynchronous |
| usb_en | input | 1 | USB device enable level |
| sys_off | input | 1 | Low-power-off mode flag |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| reg_on | output | 1 | Regulator enable |
| pwr_ready | output | 1 | Settling period elapsed |
| irq | output | 1 | Combined interrupt |
| wake_req | output | 1 | One-cycle wake/reset request |
| rst_reason_vbus | output | 1 | Sticky VBUS reset-reason bit |
| pub_stb | output | 3 | Publish strobes: detected, removed, power-ready |
| pub_chan | output | 3*CHAN_W | Channel index for each strobe |

## Verification
The bench builds the block with SETTLE_CYC = 20 in place of the millisecond-scale default. This brings ready, drop-out and restart of the settling period within a few dozen cycles, so the test can turn the regulator off part-way through a settling period and check that the full period starts again. CHAN_W keeps its default of 8, so the channel values read back and carried on the strobes fill the whole field.

// File: rtl/usbsup_pkg.sv
package usbsup_pkg;
  localparam int DATA_W  = 32;
  localparam int NUM_EV  = 3;
  localparam int EV_DET  = 0;
  localparam int EV_REM  = 1;
  localparam int EV_RDY  = 2;
  localparam int OFS_EV     = 'h100;
  localparam int OFS_PUB    = 'h180;
  localparam int OFS_MASK   = 'h300;
  localparam int OFS_MSET   = 'h304;
  localparam int OFS_MCLR   = 'h308;
  localparam int OFS_STATUS = 'h400;
  localparam int PUB_EN_BIT = 31;
endpackage

// File: rtl/usbsup_vbus_sync.sv
module usbsup_vbus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic vbus_async,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              lvl_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      lvl_d <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], vbus_async};
      lvl_d <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~lvl_d;
  assign fall = ~lvl & lvl_d;

  // R3
  sync_path_chk: assert property (@(posedge clk) disable iff (rst)
    (lvl != $past(lvl)) |-> (lvl == $past(chain[STAGES-2])));
endmodule

// File: rtl/usbsup_power.sv
module usbsup_power #(
  parameter int SETTLE_CYC = 48000
) (
  input  logic clk,
  input  logic rst,
  input  logic usb_en,
  input  logic vbus_lvl,
  input  logic vbus_rise,
  input  logic sys_off,
  output logic reg_on,
  output logic rdy,
  output logic rdy_pulse,
  output logic wake_req,
  output logic reason
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

  logic             on_nxt;
  logic [CNT_W-1:0] cnt;

  assign on_nxt = usb_en & vbus_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_on    <= 1'b0;
      rdy       <= 1'b0;
      rdy_pulse <= 1'b0;
      cnt       <= '0;
    end else begin
      reg_on    <= on_nxt;
      rdy_pulse <= 1'b0;
      if (!on_nxt) begin
        cnt <= '0;
        rdy <= 1'b0;
      end else if (reg_on && !rdy) begin
        if (cnt == LAST) begin
          rdy       <= 1'b1;
          rdy_pulse <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_req <= 1'b0;
      reason   <= 1'b0;
    end else begin
      wake_req <= vbus_rise & sys_off;
      if (vbus_rise && sys_off) reason <= 1'b1;
    end
  end

  // R1
  reg_on_cond_chk: assert property (@(posedge clk) disable iff (rst)
    reg_on |-> $past(usb_en && vbus_lvl));
  // R2
  ready_needs_on_chk: assert property (@(posedge clk) disable iff (rst)
    rdy |-> reg_on);
  // R10
  reason_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $past(reason) |-> reason);
endmodule

// File: rtl/usbsup_regs.sv
module usbsup_regs
  import usbsup_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CHAN_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_EV-1:0]        ev_set,
  input  logic                     vbus_lvl,
  input  logic                     pwr_rdy,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     wr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     rd,
  output logic [DATA_W-1:0]        rdata,
  output logic                     irq,
  output logic [NUM_EV-1:0]        pub_stb,
  output logic [NUM_EV*CHAN_W-1:0] pub_chan
);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(OFS_MSET);
  localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(OFS_MCLR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STATUS);

  logic [NUM_EV-1:0] flag;
  logic [NUM_EV-1:0] mask;
  logic [DATA_W-1:0] pub_rd [NUM_EV];
  logic [DATA_W-1:0] rd_nxt;
  logic              unused_wbits;

  assign unused_wbits = ^wdata[PUB_EN_BIT-1:CHAN_W];

  for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
    localparam logic [ADDR_W-1:0] A_EV  = ADDR_W'(OFS_EV + 4 * g);
    localparam logic [ADDR_W-1:0] A_PUB = ADDR_W'(OFS_PUB + 4 * g);
    logic              flag_q;
    logic              en_q;
    logic [CHAN_W-1:0] ch_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q <= 1'b0;
      end else if (ev_set[g]) begin
        flag_q <= 1'b1;
      end else if (wr && addr == A_EV && !wdata[0]) begin
        flag_q <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        en_q <= 1'b0;
        ch_q <= '0;
      end else if (wr && addr == A_PUB) begin
        en_q <= wdata[PUB_EN_BIT];
        ch_q <= wdata[CHAN_W-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pub_stb[g]                     <= 1'b0;
        pub_chan[g*CHAN_W +: CHAN_W]   <= '0;
      end else begin
        pub_stb[g]                     <= ev_set[g] & en_q;
        pub_chan[g*CHAN_W +: CHAN_W]   <= ch_q;
      end
    end

    assign flag[g]   = flag_q;
    assign pub_rd[g] = {en_q, {(DATA_W-1-CHAN_W){1'b0}}, ch_q};

    // R4
    hw_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      $past(ev_set[g]) |-> flag_q);
    // R8
    pub_origin_chk: assert property (@(posedge clk) disable iff (rst)
      pub_stb[g] |-> $past(ev_set[g]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '0;
    end else if (wr && addr == A_MASK) begin
      mask <= wdata[NUM_EV-1:0];
    end else if (wr && addr == A_MSET) begin
      mask <= mask | wdata[NUM_EV-1:0];
    end else if (wr && addr == A_MCLR) begin
      mask <= mask & ~wdata[NUM_EV-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flag & mask);
  end

  always_comb begin
    rd_nxt = '0;
    if (addr == A_MASK || addr == A_MSET || addr == A_MCLR) begin
      rd_nxt[NUM_EV-1:0] = mask;
    end else if (addr == A_STAT) begin
      rd_nxt[1:0] = {pwr_rdy, vbus_lvl};
    end
    for (int i = 0; i < NUM_EV; i++) begin
      if (addr == ADDR_W'(OFS_EV + 4 * i))  rd_nxt[0] = flag[i];
      if (addr == ADDR_W'(OFS_PUB + 4 * i)) rd_nxt    = pub_rd[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_nxt;
    else         rdata <= '0;
  end

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    $past(mask == '0) |-> !irq);
  // R6
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    $past(wr && addr == A_MSET) |->
      ((mask & $past(wdata[NUM_EV-1:0])) == $past(wdata[NUM_EV-1:0])));
endmodule

// File: rtl/usb_supply_seq.sv
module usb_supply_seq
  import usbsup_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int CHAN_W     = 8,
  parameter int SETTLE_CYC = 48000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     vbus_async,
  input  logic                     usb_en,
  input  logic                     sys_off,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic [31:0]              bus_wdata,
  input  logic                     bus_rd,
  output logic [31:0]              bus_rdata,
  output logic                     reg_on,
  output logic                     pwr_ready,
  output logic                     irq,
  output logic                     wake_req,
  output logic                     rst_reason_vbus,
  output logic [2:0]               pub_stb,
  output logic [3*CHAN_W-1:0]      pub_chan
);
  logic              vbus_lvl, vbus_rise, vbus_fall, rdy_pulse;
  logic [NUM_EV-1:0] ev_set;

  usbsup_vbus_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .vbus_async(vbus_async),
    .lvl(vbus_lvl), .rise(vbus_rise), .fall(vbus_fall)
  );

  usbsup_power #(.SETTLE_CYC(SETTLE_CYC)) u_power (
    .clk(clk), .rst(rst), .usb_en(usb_en), .vbus_lvl(vbus_lvl),
    .vbus_rise(vbus_rise), .sys_off(sys_off), .reg_on(reg_on),
    .rdy(pwr_ready), .rdy_pulse(rdy_pulse), .wake_req(wake_req),
    .reason(rst_reason_vbus)
  );

  always_comb begin
    ev_set         = '0;
    ev_set[EV_DET] = vbus_rise;
    ev_set[EV_REM] = vbus_fall;
    ev_set[EV_RDY] = rdy_pulse;
  end

  usbsup_regs #(.ADDR_W(ADDR_W), .CHAN_W(CHAN_W)) u_regs (
    .clk(clk), .rst(rst), .ev_set(ev_set), .vbus_lvl(vbus_lvl),
    .pwr_rdy(pwr_ready), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .rd(bus_rd), .rdata(bus_rdata), .irq(irq), .pub_stb(pub_stb),
    .pub_chan(pub_chan)
  );

  // R10
  wake_reason_chk: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> rst_reason_vbus);
  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(reg_on) |-> !pwr_ready);
endmodule

// File: tb/usb_supply_seq_bench.sv
module usb_supply_seq_bench;
  localparam int SETTLE = 20;
  localparam int CW     = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vbus_async = 1'b0, usb_en = 1'b0, sys_off = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        reg_on, pwr_ready, irq, wake_req, rst_reason_vbus;
  logic [2:0]  pub_stb;
  logic [3*CW-1:0] pub_chan;

  int tests = 0, fails = 0;
  int pub_cnt [3];
  logic [CW-1:0] pub_last [3];
  int wake_cnt = 0;
  bit finished = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  usb_supply_seq #(.ADDR_W(12), .CHAN_W(CW), .SETTLE_CYC(SETTLE)) u_usb_supply_seq (
    .clk(clk), .rst(rst), .vbus_async(vbus_async), .usb_en(usb_en),
    .sys_off(sys_off), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .reg_on(reg_on), .pwr_ready(pwr_ready), .irq(irq), .wake_req(wake_req),
    .rst_reason_vbus(rst_reason_vbus), .pub_stb(pub_stb), .pub_chan(pub_chan)
  );

  initial begin
    for (int i = 0; i < 3; i++) begin pub_cnt[i] = 0; pub_last[i] = '0; end
  end

  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < 3; i++) begin
        if (pub_stb[i]) begin
          pub_cnt[i]  = pub_cnt[i] + 1;
          pub_last[i] = pub_chan[i*CW +: CW];
        end
      end
      if (wake_req) wake_cnt = wake_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // {usb_en, vbus, exp reg_on, exp status[1:0]}
  localparam logic [4:0] VEC [7] = '{
    5'b00_0_00, 5'b10_0_00, 5'b11_1_11, 5'b01_0_01,
    5'b11_1_11, 5'b10_0_00, 5'b00_0_00
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(2);
    // reset state
    chk("R1 reset reg_on", 32'(reg_on), 0);
    chk("R9 reset irq", 32'(irq), 0);
    rd(12'h300, rv); chk("R5 reset mask", rv, 0);
    rd(12'h400, rv); chk("R7 reset status", rv, 0);
    rd(12'h180, rv); chk("R8 reset publish", rv, 0);

    // vector walk: R1 R2 R7
    foreach (VEC[i]) begin
      usb_en = VEC[i][4]; vbus_async = VEC[i][3];
      idle(SETTLE + 10);
      chk("R1 vector reg_on", 32'(reg_on), 32'(VEC[i][2]));
      chk("R2 vector pwr_ready", 32'(pwr_ready), 32'(VEC[i][1]));
      rd(12'h400, rv); chk("R7 vector status", rv, 32'(VEC[i][1:0]));
    end
    rd(12'h108, rv); chk("R2 power-ready event", rv, 1);
    rd(12'h104, rv); chk("R3 removed event", rv, 1);
    // R4 write 1 leaves set, write 0 clears
    wr(12'h100, 32'h1); rd(12'h100, rv); chk("R4 write one keeps", rv, 1);
    for (int i = 0; i < 3; i++) wr(12'(12'h100 + 4*i), 0);
    rd(12'h100, rv); chk("R4 cleared det", rv, 0);
    rd(12'h108, rv); chk("R4 cleared rdy", rv, 0);
    wr(12'h104, 32'h1); rd(12'h104, rv); chk("R4 write one no set", rv, 0);

    // R9 masked interrupt
    vbus_async = 1'b1; idle(6);
    rd(12'h100, rv); chk("R3 detected event", rv, 1);
    chk("R9 masked irq", 32'(irq), 0);
    // R5 R6 mask access
    wr(12'h300, 32'h6); rd(12'h300, rv); chk("R5 mask load", rv, 6);
    wr(12'h308, 32'h6); wr(12'h304, 32'h5);
    rd(12'h304, rv); chk("R6 set readback", rv, 5);
    wr(12'h308, 32'h4); rd(12'h308, rv); chk("R6 clear readback", rv, 1);
    wr(12'h304, 32'h0); rd(12'h300, rv); chk("R6 zero write", rv, 1);
    idle(2); chk("R9 irq raised", 32'(irq), 1);
    wr(12'h100, 0); idle(2); chk("R9 irq dropped", 32'(irq), 0);

    // R7 read-only status
    wr(12'h400, 32'h0); rd(12'h400, rv); chk("R7 read only", rv, 1);

    // R2 settle restart
    usb_en = 1'b1; idle(10);
    chk("R2 mid settle on", 32'(reg_on), 1);
    chk("R2 mid settle not ready", 32'(pwr_ready), 0);
    usb_en = 1'b0; idle(3);
    usb_en = 1'b1; idle(SETTLE - 3);
    chk("R2 restart not ready", 32'(pwr_ready), 0);
    idle(8);
    chk("R2 restart ready", 32'(pwr_ready), 1);
    usb_en = 1'b0; idle(2);
    chk("R2 off clears ready", 32'(pwr_ready), 0);

    // R8 publish
    wr(12'h180, 32'h0000_0011);
    wr(12'h184, 32'h8000_00A5);
    rd(12'h184, rv); chk("R8 publish readback", rv, 32'h8000_00A5);
    vbus_async = 1'b0; idle(6);
    vbus_async = 1'b1; idle(6);
    chk("R8 removed strobe count", 32'(pub_cnt[1]), 1);
    chk("R8 removed channel", 32'(pub_last[1]), 32'hA5);
    chk("R8 disabled no strobe", 32'(pub_cnt[0]), 0);

    // R10 wake
    chk("R10 no wake when on", 32'(wake_cnt), 0);
    chk("R10 no reason yet", 32'(rst_reason_vbus), 0);
    vbus_async = 1'b0; idle(6);
    sys_off = 1'b1; vbus_async = 1'b1; idle(6);
    chk("R10 wake pulse", 32'(wake_cnt), 1);
    sys_off = 1'b0; idle(3);
    chk("R10 reason sticky", 32'(rst_reason_vbus), 1);

    // R11 unmapped
    wr(12'h200, 32'hFFFF_FFFF);
    rd(12'h300, rv); chk("R11 unmapped write ignored", rv, 1);
    rd(12'h200, rv); chk("R11 unmapped read", rv, 0);
    rd(12'h10C, rv); chk("R11 gap read", rv, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule